// File: doc/BRIEF.md
# Clock Strap Latch and Output Mode Controller

This block sits between the pins of a clock generator and its synthesis core. At power-up it samples a set of dual-purpose pins that later carry clock outputs. Five of them give a hardware frequency code. One decides what a shared pin does. One picks the rate of an auxiliary 24/48 MHz output. A pin left floating falls back to a fixed default level. After capture, the block works out which index into the frequency table is in use. It chooses between the strapped code and a six-bit code that software writes into scattered bits of a selection register.

The block also turns the register bank's enable fields into run controls for each output. A stopped output is held low. A global tristate bit overrides every enable and floats all outputs. The block decodes the spread-spectrum setting into a compact mode code. On the shared pin it does one of two jobs. It either takes an active-low power-down request, or it acts as an open-drain reset output that pulls low for a fixed number of millisecond ticks when a watchdog expires.

Top module: `clkmode_ctrl`

## Requirements
- R1: Strap values are loaded only in a cycle where `pwrup_done` is high. Pin activity at any other time leaves `strap_status`, `sel_24m` and the shared-pin role unchanged.
- R2: A pin whose float flag is set reads as its default: FS0=1, FS1=0, FS2=1, FS3=1, FS4=0, mode=1, 24/48 select=1. Before the first capture, the straps hold these defaults. `strap_status` bit i carries FSi.
- R3: When `cfg_sel[3]`=0, `freq_idx` = {0, FS4..FS0}. When `cfg_sel[3]`=1, `freq_idx` = {`cfg_sel[1]`, `cfg_sel[2]`, `cfg_sel[7:4]`}, so index bit 5 comes from `cfg_sel[1]` and index bit 4 from `cfg_sel[2]`.
- R4: `cfg_ss` bit 1 enables spread, bit 0 picks center (1) or down (0), and bit 2 picks the deeper setting. `ss_mode` = {1, center, depth} when enabled and 000 otherwise.
- R5: `sel_24m` follows the latched 24/48 strap: 1 selects 24 MHz, 0 selects 48 MHz.
- R6: With no tristate and no power-down, each run bit equals its enable bit. A 0 stops the output and holds it low, and `out_hiz` stays 0.
- R7: `cfg_sel[0]`=1 drives `out_hiz` to 1 and forces every run bit to 0, whatever the enables are.
- R8: With mode strap 1, a low `pd_pin` raises `pwr_down` and forces every run bit to 0. With mode strap 0, `pd_pin` has no effect.
- R9: With mode strap 0, a `wdt_expire` pulse makes `rst_pull_low` high from the next cycle until the PULSE_MS-th (default 4) `ms_tick` after it. An expiry that arrives during a pulse does not extend the pulse. With mode strap 1, expiries never pull the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pwrup_done | input | 1 | One-cycle pulse that captures the straps |
| fs_in | input | 5 | Raw levels on the frequency strap pins |
| fs_float | input | 5 | 1 marks a frequency strap pin as floating |
| mode_in | input | 1 | Raw level on the mode strap pin |
| mode_float | input | 1 | Mode strap pin floating |
| sio_in | input | 1 | Raw level on the 24/48 strap pin |
| sio_float | input | 1 | 24/48 strap pin floating |
| cfg_ss | input | 3 | Spread-spectrum control bits |
| cfg_sel | input | 8 | Selection register: software code, source select, tristate |
| cfg_sdram_en | input | N_SDRAM | Memory clock enables |
| cfg_pci_en | input | N_PCI | Bus clock enables |
| cfg_aux_en | input | N_AUX | Chipset, fixed-rate and reference clock enables |
| cfg_cpu_en | input | N_CPU | Processor clock enables |
| pd_pin | input | 1 | Level on the shared pin, used as an input |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| wdt_expire | input | 1 | Watchdog timeout pulse |
| freq_idx | output | 6 | Active frequency table index |
| strap_status | output | 5 | Latched FS4..FS0 for read-back |
| sel_24m | output | 1 | 1 selects 24 MHz on the auxiliary output |
| ss_mode | output | 3 | {enabled, center, deep} spread mode |
| sdram_run | output | N_SDRAM | Memory clock run controls |
| pci_run | output | N_PCI | Bus clock run controls |
| aux_run | output | N_AUX | Auxiliary clock run controls |
| cpu_run | output | N_CPU | Processor clock run controls |
| out_hiz | output | 1 | Float all clock outputs |
| pwr_down | output | 1 | Power-down request is active |
| rst_pull_low | output | 1 | Open-drain pull-down on the shared pin |

## Verification
The bench gets each strap into a known state by pulsing `pwrup_done`, then wiggles the pins to show that a design which latched continuously would let `strap_status` drift. It drives software codes with bits 1 and 2 of `cfg_sel` set differently. A design that wired the two upper index bits in the wrong order would report the wrong index. It also uses hardware mode with software bits set, which would expose a design that leaked into bit 5. In the watchdog corner, an expiry lands halfway through a pulse. A design that retriggers would stay low past the fourth tick, and one that counts from the wrong edge would release a tick early or late. Tristate and power-down are tried with all enables set, and power-down is tried again with the reset role strapped, where a low pin must do nothing.

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl #(
  parameter int N_SDRAM  = 8,
  parameter int N_PCI    = 8,
  parameter int N_AUX    = 8,
  parameter int N_CPU    = 2,
  parameter int PULSE_MS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwrup_done,
  input  logic [4:0]         fs_in,
  input  logic [4:0]         fs_float,
  input  logic               mode_in,
  input  logic               mode_float,
  input  logic               sio_in,
  input  logic               sio_float,
  input  logic [2:0]         cfg_ss,
  input  logic [7:0]         cfg_sel,
  input  logic [N_SDRAM-1:0] cfg_sdram_en,
  input  logic [N_PCI-1:0]   cfg_pci_en,
  input  logic [N_AUX-1:0]   cfg_aux_en,
  input  logic [N_CPU-1:0]   cfg_cpu_en,
  input  logic               pd_pin,
  input  logic               ms_tick,
  input  logic               wdt_expire,
  output logic [5:0]         freq_idx,
  output logic [4:0]         strap_status,
  output logic               sel_24m,
  output logic [2:0]         ss_mode,
  output logic [N_SDRAM-1:0] sdram_run,
  output logic [N_PCI-1:0]   pci_run,
  output logic [N_AUX-1:0]   aux_run,
  output logic [N_CPU-1:0]   cpu_run,
  output logic               out_hiz,
  output logic               pwr_down,
  output logic               rst_pull_low
);

  localparam int CW = $clog2(PULSE_MS + 1);
  localparam logic [4:0] FS_DFLT = 5'b01101;
  localparam logic [CW-1:0] CNT_LAST = CW'(PULSE_MS - 1);

  logic [4:0]    fs_q;
  logic          mode_q, sio_q;
  logic          pulse_on;
  logic [CW-1:0] pulse_cnt;

  wire [4:0] fs_pin   = (fs_in & ~fs_float) | (FS_DFLT & fs_float);
  wire       mode_pin = mode_float | mode_in;
  wire       sio_pin  = sio_float | sio_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= FS_DFLT;
      mode_q <= 1'b1;
      sio_q  <= 1'b1;
    end else if (pwrup_done) begin
      fs_q   <= fs_pin;
      mode_q <= mode_pin;
      sio_q  <= sio_pin;
    end
  end

  assign strap_status = fs_q;
  assign sel_24m      = sio_q;

  wire sw_src = cfg_sel[3];
  assign freq_idx = sw_src ? {cfg_sel[1], cfg_sel[2], cfg_sel[7:4]} : {1'b0, fs_q};

  assign ss_mode = cfg_ss[1] ? {1'b1, cfg_ss[0], cfg_ss[2]} : 3'b000;

  assign out_hiz  = cfg_sel[0];
  assign pwr_down = mode_q & ~pd_pin;
  wire   gate_ok  = ~out_hiz & ~pwr_down;

  assign sdram_run = cfg_sdram_en & {N_SDRAM{gate_ok}};
  assign pci_run   = cfg_pci_en   & {N_PCI{gate_ok}};
  assign aux_run   = cfg_aux_en   & {N_AUX{gate_ok}};
  assign cpu_run   = cfg_cpu_en   & {N_CPU{gate_ok}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_on  <= 1'b0;
      pulse_cnt <= '0;
    end else if (mode_q) begin
      pulse_on  <= 1'b0;
      pulse_cnt <= '0;
    end else if (pulse_on) begin
      if (ms_tick) begin
        if (pulse_cnt == CNT_LAST) begin
          pulse_on  <= 1'b0;
          pulse_cnt <= '0;
        end else begin
          pulse_cnt <= pulse_cnt + 1'b1;
        end
      end
    end else if (wdt_expire) begin
      pulse_on  <= 1'b1;
      pulse_cnt <= '0;
    end
  end

  assign rst_pull_low = pulse_on & ~mode_q;

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrup_done |=> ($stable(fs_q) && $stable(mode_q) && $stable(sio_q)));

  // R9
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_on) |-> $past(wdt_expire));

  // R9
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_on) |-> ($past(ms_tick) || $past(mode_q)));

  // R9
  pulse_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt < CW'(PULSE_MS));

  // R8
  pd_role_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && $past(mode_q)) |-> !pulse_on);

  // R7
  tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_hiz |-> (sdram_run == '0 && pci_run == '0 && aux_run == '0 && cpu_run == '0));

endmodule

// File: tb/clkmode_ctrl_tb_top.sv
module clkmode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrup_done = 1'b0;
  logic [4:0] fs_in = '0, fs_float = '0;
  logic mode_in = 1'b1, mode_float = 1'b0, sio_in = 1'b1, sio_float = 1'b0;
  logic [2:0] cfg_ss = '0;
  logic [7:0] cfg_sel = '0;
  logic [7:0] cfg_sdram_en = '0, cfg_pci_en = '0, cfg_aux_en = '0;
  logic [1:0] cfg_cpu_en = '0;
  logic pd_pin = 1'b1, ms_tick = 1'b0, wdt_expire = 1'b0;

  logic [5:0] freq_idx;
  logic [4:0] strap_status;
  logic sel_24m, out_hiz, pwr_down, rst_pull_low;
  logic [2:0] ss_mode;
  logic [7:0] sdram_run, pci_run, aux_run;
  logic [1:0] cpu_run;

  int tests = 0, fails = 0;
  logic [4:0] exp_fs = 5'b01101;
  logic exp_mode = 1'b1, exp_sio = 1'b1;

  clkmode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pwrup_done(pwrup_done),
    .fs_in(fs_in), .fs_float(fs_float), .mode_in(mode_in), .mode_float(mode_float),
    .sio_in(sio_in), .sio_float(sio_float), .cfg_ss(cfg_ss), .cfg_sel(cfg_sel),
    .cfg_sdram_en(cfg_sdram_en), .cfg_pci_en(cfg_pci_en), .cfg_aux_en(cfg_aux_en),
    .cfg_cpu_en(cfg_cpu_en), .pd_pin(pd_pin), .ms_tick(ms_tick), .wdt_expire(wdt_expire),
    .freq_idx(freq_idx), .strap_status(strap_status), .sel_24m(sel_24m), .ss_mode(ss_mode),
    .sdram_run(sdram_run), .pci_run(pci_run), .aux_run(aux_run), .cpu_run(cpu_run),
    .out_hiz(out_hiz), .pwr_down(pwr_down), .rst_pull_low(rst_pull_low));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] f_idx(input logic [7:0] sel, input logic [4:0] fs);
    if (sel[3]) return {sel[1], sel[2], sel[7], sel[6], sel[5], sel[4]};
    return {1'b0, fs};
  endfunction

  function automatic logic [2:0] f_ss(input logic [2:0] s);
    if (!s[1]) return 3'b000;
    return {1'b1, s[0], s[2]};
  endfunction

  function automatic logic f_strap(input logic lvl, input logic flt, input logic dflt);
    return flt ? dflt : lvl;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic capture();
    logic [4:0] d = 5'b01101;
    @(negedge clk) pwrup_done = 1'b1;
    for (int i = 0; i < 5; i++) exp_fs[i] = f_strap(fs_in[i], fs_float[i], d[i]);
    exp_mode = f_strap(mode_in, mode_float, 1'b1);
    exp_sio  = f_strap(sio_in, sio_float, 1'b1);
    @(negedge clk) pwrup_done = 1'b0;
    #1;
  endtask

  task automatic tick_ms();
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
    #1;
  endtask

  task automatic expire();
    @(negedge clk) wdt_expire = 1'b1;
    @(negedge clk) wdt_expire = 1'b0;
    #1;
  endtask

  task automatic check_cfg(input string tag);
    logic gate;
    #1;
    gate = !cfg_sel[0] && !(exp_mode && !pd_pin);
    chk(freq_idx == f_idx(cfg_sel, exp_fs), {"R3 index ", tag}, freq_idx, f_idx(cfg_sel, exp_fs));
    chk(ss_mode == f_ss(cfg_ss), {"R4 spread ", tag}, ss_mode, f_ss(cfg_ss));
    chk(sdram_run == (cfg_sdram_en & {8{gate}}) && pci_run == (cfg_pci_en & {8{gate}}) &&
        aux_run == (cfg_aux_en & {8{gate}}) && cpu_run == (cfg_cpu_en & {2{gate}}),
        {"R6 R7 R8 run gating ", tag}, {sdram_run, pci_run}, {cfg_sdram_en & {8{gate}}, cfg_pci_en & {8{gate}}});
    chk(out_hiz == cfg_sel[0], {"R7 hiz ", tag}, out_hiz, cfg_sel[0]);
    chk(pwr_down == (exp_mode && !pd_pin), {"R8 pwr_down ", tag}, pwr_down, exp_mode && !pd_pin);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++; tests++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2718));
    fs_in = 5'h12;
    pd_pin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R2 reset defaults
    chk(strap_status == 5'b01101, "R2 reset straps", strap_status, 5'b01101);
    chk(sel_24m == 1'b1, "R5 reset 24/48 select", sel_24m, 1);
    chk(rst_pull_low == 1'b0, "R9 idle after reset", rst_pull_low, 0);
    chk(pwr_down == 1'b1, "R8 default mode pd low", pwr_down, 1);
    pd_pin = 1'b1;

    // R2 all floating
    fs_float = 5'h1f; fs_in = 5'h12; mode_float = 1'b1; mode_in = 1'b0; sio_float = 1'b1; sio_in = 1'b0;
    capture();
    chk(strap_status == 5'b01101, "R2 floating straps", strap_status, 5'b01101);
    chk(sel_24m == 1'b1, "R2 floating 24/48", sel_24m, 1);

    // R1 R5 random captures, then pin changes ignored
    mode_float = 1'b0; mode_in = 1'b1;
    for (int n = 0; n < 20; n++) begin
      fs_in = 5'($urandom); fs_float = 5'($urandom); sio_in = 1'($urandom); sio_float = 1'($urandom);
      capture();
      chk(strap_status == exp_fs, "R2 captured straps", strap_status, exp_fs);
      chk(sel_24m == exp_sio, "R5 24/48 strap", sel_24m, exp_sio);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        fs_in = 5'($urandom); fs_float = 5'($urandom); sio_in = ~sio_in; mode_in = 1'($urandom);
      end
      #1;
      chk(strap_status == exp_fs, "R1 straps held", strap_status, exp_fs);
      chk(sel_24m == exp_sio, "R1 24/48 held", sel_24m, exp_sio);
      mode_in = 1'b1;
    end

    // known straps for config tests
    fs_in = 5'h1f; fs_float = 5'h00; mode_in = 1'b1;
    capture();

    // R3 directed upper bit ordering
    cfg_sel = 8'b0000_1010; #1;
    chk(freq_idx == 6'b100000, "R3 sel bit1 to idx5", freq_idx, 6'b100000);
    cfg_sel = 8'b0000_1100; #1;
    chk(freq_idx == 6'b010000, "R3 sel bit2 to idx4", freq_idx, 6'b010000);
    cfg_sel = 8'b1111_0110; #1;
    chk(freq_idx == 6'b011111, "R3 hw source ignores sw bits", freq_idx, 6'b011111);

    // R7 tristate with all enables
    cfg_sel = 8'h01; cfg_sdram_en = '1; cfg_pci_en = '1; cfg_aux_en = '1; cfg_cpu_en = '1;
    check_cfg("tristate all enabled");
    // R8 power-down with all enables
    cfg_sel = 8'h00; pd_pin = 1'b0;
    check_cfg("power-down all enabled");
    chk(out_hiz == 1'b0, "R8 pd not hiz", out_hiz, 0);
    pd_pin = 1'b1;

    // random configuration sweep
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      cfg_sel = 8'($urandom); cfg_ss = 3'($urandom);
      cfg_sdram_en = 8'($urandom); cfg_pci_en = 8'($urandom);
      cfg_aux_en = 8'($urandom); cfg_cpu_en = 2'($urandom);
      pd_pin = ($urandom % 8) != 0;
      if ((n % 4) == 0) cfg_sel[0] = 1'b0;
      check_cfg("random");
    end

    // reset-output role
    @(negedge clk);
    cfg_sel = 8'h00; cfg_sdram_en = '1; cfg_pci_en = '1; cfg_aux_en = '1; cfg_cpu_en = '1;
    mode_in = 1'b0; pd_pin = 1'b1;
    capture();
    pd_pin = 1'b0;
    check_cfg("pd pin in reset role");
    chk(pwr_down == 1'b0, "R8 pd ignored in reset role", pwr_down, 0);
    pd_pin = 1'b1;

    // R9 pulse with mid-pulse retrigger
    tick_ms();
    chk(rst_pull_low == 1'b0, "R9 tick alone no pulse", rst_pull_low, 0);
    expire();
    chk(rst_pull_low == 1'b1, "R9 pulse starts", rst_pull_low, 1);
    tick_ms();
    tick_ms();
    expire();
    chk(rst_pull_low == 1'b1, "R9 mid pulse", rst_pull_low, 1);
    tick_ms();
    chk(rst_pull_low == 1'b1, "R9 after third tick", rst_pull_low, 1);
    tick_ms();
    chk(rst_pull_low == 1'b0, "R9 retrigger ignored, ends at fourth tick", rst_pull_low, 0);

    // R9 clean full-length pulse
    expire();
    for (int k = 1; k < 4; k++) begin
      tick_ms();
      chk(rst_pull_low == 1'b1, "R9 held before fourth tick", rst_pull_low, 1);
    end
    tick_ms();
    chk(rst_pull_low == 1'b0, "R9 released at fourth tick", rst_pull_low, 0);

    // R9 power-down role ignores expiry
    mode_in = 1'b1;
    capture();
    expire();
    chk(rst_pull_low == 1'b0, "R9 expiry ignored in pd role", rst_pull_low, 0);
    tick_ms();
    chk(rst_pull_low == 1'b0, "R9 still idle in pd role", rst_pull_low, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule